// File: doc/BRIEF.md
# Paced Asynchronous Serial Receiver

This block receives asynchronous serial characters on a single input line and paces the far-end transmitter with an active-low Request-to-Send output. Bit timing comes from an external oversampling enable, `bit_tick`, which pulses `OVS` times per bit period. The receiver starts timing at the falling edge of the start bit. It checks the start bit at its midpoint, then samples 8 data bits (least significant first), an optional parity bit and one stop bit, each at mid-bit. The finished character is copied into a holding register, which raises a full flag and keeps parity and framing error flags alongside the data.

The pacing output is high whenever the block cannot take a character. That covers pacing turned off, reception disabled, the receiver being reinitialised, a frame in progress, and a programmable hold-off after each frame. The hold-off lasts `rts_dly` whole bit periods and is counted from the mid-bit sample of the stop bit. A start bit that proves false at its midpoint returns the receiver to idle with no hold-off.

Top module: `uart_rts_rx`

## Requirements
- R1: After synchronous reset, `rts_n` is 1, `rx_full`, `parity_err` and `frame_err` are 0 and `rx_data` is 0x00.
- R2: While `rts_en` is 0, `rts_n` stays 1 at all times, and characters are still received.
- R3: While `rx_en` is 1, `rts_en` is 1, `rx_init` is 0, no frame is in progress and no hold-off is pending, `rts_n` is 0. While `rx_en` is 0, `rts_n` is 1, any frame in progress is dropped and line activity loads no character.
- R4: A falling edge on `rxd` while the receiver is idle starts a frame. `rts_n` goes to 1 within 3 clock cycles of the edge and stays 1 until the frame ends.
- R5: A frame ends at the mid-bit sample of the stop bit. `rts_n` returns to 0 after `rts_dly`×`OVS` further `bit_tick` pulses. With `rts_dly` = 0 it returns to 0 in the cycle after the frame ends.
- R6: A start edge that arrives while a hold-off is pending cancels that hold-off. `rts_n` stays 1 through the new frame, and a fresh hold-off is counted from the new frame's end.
- R7: If `rxd` is 1 at the midpoint of the start bit, the receiver returns to idle, loads no character and applies no hold-off, so `rts_n` returns to 0.
- R8: The 8 data bits arrive least significant bit first. At frame end they appear on `rx_data` and `rx_full` becomes 1.
- R9: With `par_en` = 1, one parity bit follows the data. With `par_odd` = 0 the data bits and the parity bit together hold an even number of ones; with `par_odd` = 1 they hold an odd number. A mismatch sets `parity_err` together with the loaded character.
- R10: A stop bit sampled as 0 sets `frame_err` together with the loaded character.
- R11: A one-cycle `rd_strobe` clears `rx_full`, `parity_err` and `frame_err`. The error flags are sticky until then. A load in the same cycle as a read takes priority.
- R12: `rx_init` = 1 forces `rts_n` to 1 in the same cycle, drops any frame in progress and clears `rx_full`, `parity_err`, `frame_err` and `rx_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | Oversampling enable, OVS pulses per bit |
| rxd | input | 1 | Serial data in, idle high |
| rx_en | input | 1 | Receive enable |
| rx_init | input | 1 | Receiver reinitialise |
| rts_en | input | 1 | Pacing output enable |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| rts_dly | input | DLY_W | Hold-off after frame end, in bit periods |
| rd_strobe | input | 1 | Read of the holding register |
| rts_n | output | 1 | Request-to-Send, low = ready |
| rx_data | output | 8 | Last received character |
| rx_full | output | 1 | Holding register full |
| parity_err | output | 1 | Sticky parity error |
| frame_err | output | 1 | Sticky framing error |

## Verification
The receive path is exercised with several kinds of frame: alternating-bit data, single-bit data at either end of the byte, even and odd parity with correct and inverted parity bits, and a low stop bit. Together these separate bit order, parity sense and error capture. The pacing output is measured as the length of each high run on `rts_n` for hold-off values 0, 1, 3 and 15. Two back-to-back frames and a short glitch placed inside a pending hold-off show the difference between a delay that restarts, a delay that runs on, and a false start that wrongly keeps the hold-off. Frames sent with pacing off, with reception off, and followed by a reinitialise confirm which states force `rts_n` high and which clear the holding register.

// File: rtl/uart_rts_pkg.sv
package uart_rts_pkg;

    localparam int CHAR_W = 8;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic [CHAR_W-1:0] data;
        logic              perr;
        logic              ferr;
    } rx_char_t;

    // Parity bit value a correct transmitter sends for this data.
    function automatic logic expected_parity(input logic [CHAR_W-1:0] d,
                                             input logic odd_mode);
        return (^d) ^ odd_mode;
    endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rxd,
    output logic rxd_s,
    output logic fall
);
    logic [STAGES-1:0] pipe;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe <= '1;
            prev <= 1'b1;
        end else begin
            pipe <= {pipe[STAGES-2:0], rxd};
            prev <= pipe[STAGES-1];
        end
    end

    assign rxd_s = pipe[STAGES-1];
    assign fall  = prev & ~pipe[STAGES-1];
endmodule

// File: rtl/rx_frame.sv
module rx_frame
    import uart_rts_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     enable,
    input  logic     rxd_s,
    input  logic     fall,
    input  logic     par_en,
    input  logic     par_odd,
    output logic     busy,
    output logic     frame_start,
    output logic     frame_end,
    output logic     false_start,
    output rx_char_t ch
);
    localparam int CNT_W = $clog2(OVS);
    localparam int HALF  = OVS / 2;
    localparam int IDX_W = $clog2(CHAR_W);

    rx_state_e         state;
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W-1:0]  idx;
    logic [CHAR_W-1:0] shreg;
    logic              par_bad;
    logic              at_full;
    logic              at_half;

    assign at_full = tick && (cnt == CNT_W'(OVS - 1));
    assign at_half = tick && (cnt == CNT_W'(HALF - 1));

    assign busy        = (state != RX_IDLE);
    assign frame_start = enable && (state == RX_IDLE) && fall;
    assign false_start = enable && (state == RX_START) && at_half && rxd_s;
    assign frame_end   = enable && (state == RX_STOP) && at_full;

    assign ch.data = shreg;
    assign ch.perr = par_en & par_bad;
    assign ch.ferr = ~rxd_s;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            state   <= RX_IDLE;
            cnt     <= '0;
            idx     <= '0;
            par_bad <= 1'b0;
            if (rst) shreg <= '0;
        end else begin
            case (state)
                RX_IDLE: begin
                    if (fall) begin
                        state   <= RX_START;
                        cnt     <= '0;
                        par_bad <= 1'b0;
                    end
                end
                RX_START: begin
                    if (at_half) begin
                        cnt <= '0;
                        idx <= '0;
                        state <= rxd_s ? RX_IDLE : RX_DATA;
                    end else if (tick) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (at_full) begin
                        cnt   <= '0;
                        shreg <= {rxd_s, shreg[CHAR_W-1:1]};
                        if (idx == IDX_W'(CHAR_W - 1)) begin
                            state <= par_en ? RX_PAR : RX_STOP;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end else if (tick) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_PAR: begin
                    if (at_full) begin
                        cnt     <= '0;
                        par_bad <= (rxd_s != expected_parity(shreg, par_odd));
                        state   <= RX_STOP;
                    end else if (tick) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (at_full) begin
                        cnt   <= '0;
                        state <= RX_IDLE;
                    end else if (tick) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rx_rts_pace.sv
module rx_rts_pace #(
    parameter int OVS   = 16,
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             rts_en,
    input  logic             rx_en,
    input  logic             rx_init,
    input  logic             busy,
    input  logic             frame_start,
    input  logic             frame_end,
    input  logic [DLY_W-1:0] rts_dly,
    output logic             rts_n
);
    localparam int PEND_W = DLY_W + $clog2(OVS + 1);

    logic [PEND_W-1:0] pend;

    always_ff @(posedge clk) begin
        if (rst || !rx_en || rx_init) begin
            pend <= '0;
        end else if (frame_start) begin
            pend <= '0;
        end else if (frame_end) begin
            pend <= PEND_W'(rts_dly) * PEND_W'(OVS);
        end else if (tick && (pend != '0)) begin
            pend <= pend - 1'b1;
        end
    end

    assign rts_n = ~rts_en | ~rx_en | rx_init | busy | (pend != '0);
endmodule

// File: rtl/rx_hold_buf.sv
module rx_hold_buf
    import uart_rts_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clr,
    input  logic     load,
    input  rx_char_t ch_in,
    input  logic     rd,
    output rx_char_t held,
    output logic     full
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            held <= '0;
            full <= 1'b0;
        end else if (load) begin
            held.data <= ch_in.data;
            held.perr <= ch_in.perr | (held.perr & ~rd);
            held.ferr <= ch_in.ferr | (held.ferr & ~rd);
            full      <= 1'b1;
        end else if (rd) begin
            held.perr <= 1'b0;
            held.ferr <= 1'b0;
            full      <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_rts_rx.sv
module uart_rts_rx
    import uart_rts_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int DLY_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_tick,
    input  logic              rxd,
    input  logic              rx_en,
    input  logic              rx_init,
    input  logic              rts_en,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic [DLY_W-1:0]  rts_dly,
    input  logic              rd_strobe,
    output logic              rts_n,
    output logic [CHAR_W-1:0] rx_data,
    output logic              rx_full,
    output logic              parity_err,
    output logic              frame_err
);
    logic     rxd_s;
    logic     fall;
    logic     enable;
    logic     busy;
    logic     frame_start;
    logic     frame_end;
    logic     false_start;
    rx_char_t ch;
    rx_char_t held;

    assign enable = rx_en & ~rx_init;

    rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .rxd   (rxd),
        .rxd_s (rxd_s),
        .fall  (fall)
    );

    rx_frame #(.OVS(OVS)) u_frame (
        .clk         (clk),
        .rst         (rst),
        .tick        (bit_tick),
        .enable      (enable),
        .rxd_s       (rxd_s),
        .fall        (fall),
        .par_en      (par_en),
        .par_odd     (par_odd),
        .busy        (busy),
        .frame_start (frame_start),
        .frame_end   (frame_end),
        .false_start (false_start),
        .ch          (ch)
    );

    rx_rts_pace #(.OVS(OVS), .DLY_W(DLY_W)) u_pace (
        .clk         (clk),
        .rst         (rst),
        .tick        (bit_tick),
        .rts_en      (rts_en),
        .rx_en       (rx_en),
        .rx_init     (rx_init),
        .busy        (busy),
        .frame_start (frame_start),
        .frame_end   (frame_end),
        .rts_dly     (rts_dly),
        .rts_n       (rts_n)
    );

    rx_hold_buf u_buf (
        .clk   (clk),
        .rst   (rst),
        .clr   (rx_init),
        .load  (frame_end),
        .ch_in (ch),
        .rd    (rd_strobe),
        .held  (held),
        .full  (rx_full)
    );

    assign rx_data    = held.data;
    assign parity_err = held.perr;
    assign frame_err  = held.ferr;
endmodule

// File: rtl/uart_rts_rx_chk.sv
module uart_rts_rx_chk #(
    parameter int DLY_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             rx_en,
    input logic             rx_init,
    input logic             rts_en,
    input logic [DLY_W-1:0] rts_dly,
    input logic             rd_strobe,
    input logic             rts_n,
    input logic             rx_full,
    input logic             parity_err,
    input logic             frame_err,
    input logic             busy,
    input logic             frame_end,
    input logic             false_start
);
    a_r2_pacing_off: assert property (@(posedge clk) disable iff (rst)
        !rts_en |-> rts_n);

    a_r4_frame_holds_rts: assert property (@(posedge clk) disable iff (rst)
        busy |-> rts_n);

    a_r3_disable_drops_frame: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> !busy);

    a_r5_zero_delay: assert property (@(posedge clk) disable iff (rst)
        (frame_end && rts_dly == '0) ##1 (rx_en && rts_en && !rx_init && !busy)
        |-> !rts_n);

    a_r7_false_start_idle: assert property (@(posedge clk) disable iff (rst)
        false_start |=> !busy);

    a_r8_end_fills: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> rx_full);

    a_r11_read_clears: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && !frame_end && !rx_init) |=> (!rx_full && !parity_err && !frame_err));

    a_r12_init_clears: assert property (@(posedge clk) disable iff (rst)
        rx_init |=> (!busy && !rx_full && !parity_err && !frame_err));
endmodule

bind uart_rts_rx uart_rts_rx_chk #(.DLY_W(DLY_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .rx_en       (rx_en),
    .rx_init     (rx_init),
    .rts_en      (rts_en),
    .rts_dly     (rts_dly),
    .rd_strobe   (rd_strobe),
    .rts_n       (rts_n),
    .rx_full     (rx_full),
    .parity_err  (parity_err),
    .frame_err   (frame_err),
    .busy        (busy),
    .frame_end   (frame_end),
    .false_start (false_start)
);

// File: tb/uart_rts_rx_bench.sv
module uart_rts_rx_bench;
    localparam int BITC = 32;   // clocks per bit: 16 ticks, one tick every 2 clocks

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_tick = 1'b0;
    logic       rxd = 1'b1;
    logic       rx_en = 1'b0;
    logic       rx_init = 1'b0;
    logic       rts_en = 1'b0;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic [3:0] rts_dly = 4'd0;
    logic       rd_strobe = 1'b0;
    logic       rts_n;
    logic [7:0] rx_data;
    logic       rx_full;
    logic       parity_err;
    logic       frame_err;

    typedef struct {
        logic [7:0] d;
        logic       pe;
        logic       fe;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   hold_mon = 1'b0;
    bit   watch_high = 1'b0;
    int   viol = 0;
    int   hi_run = 0;
    int   last_run = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) bit_tick <= ~bit_tick;

    uart_rts_rx u_uart_rts_rx (
        .clk        (clk),
        .rst        (rst),
        .bit_tick   (bit_tick),
        .rxd        (rxd),
        .rx_en      (rx_en),
        .rx_init    (rx_init),
        .rts_en     (rts_en),
        .par_en     (par_en),
        .par_odd    (par_odd),
        .rts_dly    (rts_dly),
        .rd_strobe  (rd_strobe),
        .rts_n      (rts_n),
        .rx_data    (rx_data),
        .rx_full    (rx_full),
        .parity_err (parity_err),
        .frame_err  (frame_err)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // High-run length of rts_n and violation counter while it must stay high.
    always @(negedge clk) begin
        if (rts_n) begin
            hi_run = hi_run + 1;
        end else begin
            if (hi_run != 0) last_run = hi_run;
            hi_run = 0;
        end
        if (watch_high && !rts_n) viol = viol + 1;
    end

    task automatic send_frame(input logic [7:0] d, input bit bad_par,
                              input bit bad_stop, input bit expect_char);
        exp_t e;
        e.d  = d;
        e.pe = par_en & bad_par;
        e.fe = bad_stop;
        if (expect_char) q.push_back(e);
        rxd = 1'b0;
        repeat (BITC) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = d[i];
            repeat (BITC) @(negedge clk);
        end
        if (par_en) begin
            rxd = (^d) ^ par_odd ^ bad_par;
            repeat (BITC) @(negedge clk);
        end
        rxd = ~bad_stop;
        repeat (BITC) @(negedge clk);
        rxd = 1'b1;
    endtask

    task automatic wait_rts_low();
        int n = 0;
        while (rts_n && n < 1000) begin
            @(negedge clk);
            n++;
        end
        @(negedge clk);
    endtask

    task automatic check_run(input int exp, input string tag);
        int diff;
        diff = last_run - exp;
        if (diff < 0) diff = -diff;
        check(diff <= 6, tag, last_run, exp);
    endtask

    // Scoreboard monitor: pops expected characters as the design delivers them.
    initial begin
        forever begin
            @(negedge clk);
            if (rx_full && !hold_mon) begin
                if (q.size() == 0) begin
                    check(1'b0, "R8 unexpected character", rx_data, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(rx_data == e.d, "R8 data", rx_data, e.d);
                    check(parity_err == e.pe, "R9 parity flag", parity_err, e.pe);
                    check(frame_err == e.fe, "R10 framing flag", frame_err, e.fe);
                end
                rd_strobe = 1'b1;
                @(negedge clk);
                rd_strobe = 1'b0;
                check(!rx_full && !parity_err && !frame_err, "R11 read clears",
                      {rx_full, parity_err, frame_err}, 0);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(rts_n == 1'b1, "R1 rts_n after reset", rts_n, 1);
        check(!rx_full && !parity_err && !frame_err, "R1 flags after reset",
              {rx_full, parity_err, frame_err}, 0);
        check(rx_data == 8'h00, "R1 data after reset", rx_data, 0);

        rx_en = 1'b1;
        rts_en = 1'b1;
        @(negedge clk);
        check(rts_n == 1'b0, "R3 ready when idle", rts_n, 0);

        // R8 / R4 / R5: zero hold-off, no parity
        send_frame(8'hA5, 0, 0, 1);
        wait_rts_low();
        check_run(304, "R5 zero delay run");
        send_frame(8'h01, 0, 0, 1);
        send_frame(8'h80, 0, 0, 1);

        // R9: even and odd parity, good and bad
        par_en = 1'b1;
        par_odd = 1'b0;
        send_frame(8'h37, 0, 0, 1);
        send_frame(8'h37, 1, 0, 1);
        par_odd = 1'b1;
        send_frame(8'hC8, 0, 0, 1);
        send_frame(8'hC8, 1, 0, 1);

        // R10: low stop bit
        send_frame(8'h5A, 0, 1, 1);
        repeat (BITC) @(negedge clk);

        // R5: hold-off of 3 bits with parity, 1 bit without
        rts_dly = 4'd3;
        send_frame(8'h6E, 0, 0, 1);
        wait_rts_low();
        check_run(336 + 96, "R5 delay 3 run");
        par_en = 1'b0;
        rts_dly = 4'd1;
        send_frame(8'h4D, 0, 0, 1);
        wait_rts_low();
        check_run(304 + 32, "R5 delay 1 run");

        // R6: back-to-back frames during a pending hold-off
        rts_dly = 4'd15;
        send_frame(8'h11, 0, 0, 1);
        send_frame(8'h22, 0, 0, 1);
        wait_rts_low();
        check_run(320 + 304 + 480, "R6 restarted delay run");

        // R6 / R7: glitch inside a pending hold-off
        send_frame(8'h33, 0, 0, 1);
        repeat (20) @(negedge clk);
        check(rts_n == 1'b1, "R5 hold-off pending", rts_n, 1);
        rxd = 1'b0;
        repeat (8) @(negedge clk);
        rxd = 1'b1;
        repeat (40) @(negedge clk);
        check(rts_n == 1'b0, "R7 false start no delay", rts_n, 0);
        check(q.size() == 0 && !rx_full, "R7 no character", q.size(), 0);

        // R2: pacing off
        rts_dly = 4'd0;
        rts_en = 1'b0;
        viol = 0;
        watch_high = 1'b1;
        send_frame(8'h99, 0, 0, 1);
        repeat (BITC) @(negedge clk);
        watch_high = 1'b0;
        check(viol == 0, "R2 rts_n held high", viol, 0);
        rts_en = 1'b1;
        @(negedge clk);
        check(rts_n == 1'b0, "R3 ready again", rts_n, 0);

        // R3: reception off
        rx_en = 1'b0;
        viol = 0;
        watch_high = 1'b1;
        send_frame(8'h55, 0, 0, 0);
        repeat (5) @(negedge clk);
        watch_high = 1'b0;
        check(viol == 0, "R3 rts_n high when disabled", viol, 0);
        check(!rx_full && q.size() == 0, "R3 frame ignored", rx_full, 0);
        rx_en = 1'b1;
        @(negedge clk);
        check(rts_n == 1'b0, "R3 ready after enable", rts_n, 0);

        // R12: reinitialise clears a full holding register
        hold_mon = 1'b1;
        send_frame(8'hC3, 0, 0, 1);
        repeat (5) @(negedge clk);
        check(rx_full == 1'b1 && rx_data == 8'hC3, "R8 held character", rx_data, 8'hC3);
        rx_init = 1'b1;
        #1;
        check(rts_n == 1'b1, "R12 rts_n forced", rts_n, 1);
        @(negedge clk);
        rx_init = 1'b0;
        check(!rx_full && !parity_err && !frame_err && rx_data == 8'h00,
              "R12 buffer cleared", {rx_full, rx_data}, 0);
        void'(q.pop_front());
        hold_mon = 1'b0;
        @(negedge clk);
        check(rts_n == 1'b0, "R12 ready after init", rts_n, 0);

        repeat (200) @(negedge clk);
        check(q.size() == 0, "R8 all characters delivered", q.size(), 0);
        finish_run();
    end
endmodule